// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a digital subsystem. It merges two requests. One is a supply-low flag that an external comparator delivers already synchronous to the block clock. The other is an active-low manual reset input that a bare pushbutton may drive directly. Reset is held for as long as either request is present. After the last request goes away, reset stays on for a fixed number of clock cycles, and only then is it released. The same stretch follows a power-on reset of the block itself.

The manual input passes through a synchroniser chain. A change of its level counts only after it has held steady for a set number of cycles, so switch bounce never needs external parts. Reset is driven on two pins, one active low and one active high. Both come from flops loaded from the same next-state value, so they switch on the same edge.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, reset is asserted (`rst_out_n`=0, `rst_out`=1). After `por_n` rises between two edges, reset stays asserted and is released at exactly the STRETCH_CYC-th rising edge after that.
- R2: `rst_out` is always the inverse of `rst_out_n`, and both change only on the same rising edge.
- R3: A rising edge that samples `supply_low`=1 asserts reset at that edge.
- R4: Reset is released at exactly the STRETCH_CYC-th rising edge after the last edge that saw an active source, and stays released while no source is active.
- R5: If a source becomes active again while reset is being stretched, the stretch count restarts from zero.
- R6: `mr_n` passes through SYNC_STAGES flops (default 2). A synchronised low counts as a press only once it has persisted for FILT_CYC consecutive edges. With the default two stages, reset asserts at the (FILT_CYC+3)-th edge after `mr_n` falls between edges.
- R7: A low pulse on `mr_n` that lasts fewer than FILT_CYC cycles has no effect: reset stays released.
- R8: The end of a press is filtered the same way. A synchronised high must persist for FILT_CYC edges, and any shorter bounce restarts that run. Reset is released at the (FILT_CYC+2+STRETCH_CYC)-th edge after the final rise of `mr_n`.
- R9: With both sources active, reset stays asserted until the later of the two has ended, and the stretch is counted from that later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| supply_low | input | 1 | Synchronous flag, 1 = supply below threshold |
| mr_n | input | 1 | Manual reset request from a switch, active low, asynchronous |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high, inverse of rst_out_n |

## Verification
On every cycle, the assertions check that the two outputs agree, that an active source forces reset on the following edge, and that the stretch counter restarts whenever a source reappears. They also check that reset falls only from the final count, that the filter accepts a level change only at the end of a full run, and that the filter counter stays within its range. Only the bench scenarios can show the end-to-end cycle counts from a pin change to the output: the exact press latency, the exact release instant after each kind of source, and the effect of retriggers and overlapping sources. The same holds for the behaviours that depend on how the stimulus is shaped: a glitch one cycle too short, a pulse exactly at the threshold, and bounce on release.

// File: rtl/rstsup_pkg.sv
`timescale 1ns/1ps
package rstsup_pkg;

  typedef enum logic {
    MR_IDLE = 1'b0,
    MR_HELD = 1'b1
  } mr_state_e;

  // Counter width able to hold 0 .. n-1
  function automatic int unsigned width_for(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // True when a run counter sits on its final value for a limit of `limit`
  function automatic logic last_tick(int unsigned count, int unsigned limit);
    return count == limit - 1;
  endfunction

endpackage

// File: rtl/rstsup_sync.sv
`timescale 1ns/1ps
module rstsup_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q_r;
    if (i == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= g_stage[i-1].q_r;
      end
    end
  end

  assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/rstsup_filter.sv
`timescale 1ns/1ps
module rstsup_filter
  import rstsup_pkg::*;
#(
  parameter int unsigned FILT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,   // synchronised manual input, active low
  output logic pressed
);

  localparam int unsigned FW = width_for(FILT_CYC);

  mr_state_e     state;
  logic [FW-1:0] run_cnt;
  logic          differs;   // input level disagrees with accepted state
  logic          accept;    // run complete, flip accepted state

  assign differs = (state == MR_IDLE) ? ~level_n : level_n;
  assign accept  = differs && last_tick(32'(run_cnt), FILT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MR_IDLE;
      run_cnt <= '0;
    end else if (!differs) begin
      run_cnt <= '0;
    end else if (accept) begin
      state   <= (state == MR_IDLE) ? MR_HELD : MR_IDLE;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + FW'(1);
    end
  end

  assign pressed = (state == MR_HELD);

  // R6: a press is taken only at the end of a full low run
  p_press_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pressed) |-> ($past(differs) && $past(run_cnt) == FW'(FILT_CYC - 1)));

  // R8: a release is taken only at the end of a full high run
  p_release_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pressed) |-> ($past(differs) && $past(run_cnt) == FW'(FILT_CYC - 1)));

  // R7: a partial run never changes the accepted state
  p_short_run_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt != FW'(FILT_CYC - 1)) |=> $stable(pressed));

  // R7: the run counter stays below the filter length
  p_run_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run_cnt) < FILT_CYC);

endmodule

// File: rtl/rstsup_stretch.sv
`timescale 1ns/1ps
module rstsup_stretch
  import rstsup_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 40_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_act,   // any reset source active this cycle
  output logic hold_d     // next value of the reset state
);

  localparam int unsigned CW = width_for(STRETCH_CYC);

  logic [CW-1:0] cnt;
  logic          hold;
  logic          expire;   // final stretch cycle reached with no source

  assign expire = hold && !src_act && last_tick(32'(cnt), STRETCH_CYC);
  assign hold_d = src_act || (hold && !expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= 1'b1;
      cnt  <= '0;
    end else begin
      hold <= hold_d;
      if (src_act || expire || !hold) cnt <= '0;
      else                            cnt <= cnt + CW'(1);
    end
  end

  // R3: an active source holds reset on the next edge
  p_src_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_act |=> hold);

  // R5: a source restarts the stretch count
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_act |=> (cnt == '0));

  // R4: reset falls only from the final count with no source present
  p_release_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> ($past(cnt) == CW'(STRETCH_CYC - 1) && !$past(src_act)));

  // R4: the count never passes its limit
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < STRETCH_CYC);

endmodule

// File: rtl/rst_supervisor.sv
`timescale 1ns/1ps
module rst_supervisor #(
  parameter int unsigned STRETCH_CYC = 40_000_000,  // reset stretch in clock cycles
  parameter int unsigned FILT_CYC    = 16,          // manual input stable run
  parameter int unsigned SYNC_STAGES = 2            // synchroniser depth
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic mr_n,
  output logic rst_out_n,
  output logic rst_out
);

  logic mr_sync_n;
  logic mr_pressed;
  logic src_act;
  logic hold_d;
  logic rst_n_q;
  logic rst_q;

  rstsup_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) i_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (mr_n),
    .q     (mr_sync_n)
  );

  rstsup_filter #(
    .FILT_CYC (FILT_CYC)
  ) i_filter (
    .clk     (clk),
    .rst_n   (por_n),
    .level_n (mr_sync_n),
    .pressed (mr_pressed)
  );

  assign src_act = supply_low || mr_pressed;

  rstsup_stretch #(
    .STRETCH_CYC (STRETCH_CYC)
  ) i_stretch (
    .clk     (clk),
    .rst_n   (por_n),
    .src_act (src_act),
    .hold_d  (hold_d)
  );

  // Two output flops loaded from one next-state value
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      rst_n_q <= ~hold_d;
      rst_q   <= hold_d;
    end
  end

  assign rst_out_n = rst_n_q;
  assign rst_out   = rst_q;

  // R2: the two outputs never disagree
  p_outputs_agree_r2: assert property (@(posedge clk) disable iff (!por_n)
    rst_out == !rst_out_n);

  // R3: supply low forces reset at the next edge
  p_supply_asserts_r3: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> !rst_out_n);

  // R9: an accepted press keeps reset on regardless of the supply flag
  p_press_asserts_r9: assert property (@(posedge clk) disable iff (!por_n)
    mr_pressed |=> rst_out);

endmodule

// File: tb/test_rst_supervisor.sv
`timescale 1ns/1ps
module test_rst_supervisor;

  localparam int unsigned LIM = 16;
  localparam int unsigned FLT = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low = 1'b0;
  logic mr_n = 1'b1;
  logic rst_out_n;
  logic rst_out;

  always #2.5 clk = ~clk;  // 200 MHz

  rst_supervisor #(
    .STRETCH_CYC (LIM),
    .FILT_CYC    (FLT),
    .SYNC_STAGES (2)
  ) i_rst_supervisor (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .mr_n       (mr_n),
    .rst_out_n  (rst_out_n),
    .rst_out    (rst_out)
  );

  typedef struct {
    int    cyc;
    bit    asserted;
    string tag;
  } exp_t;

  exp_t expq[$];
  int   cyc   = 0;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit exp_asserted, string tag);
    total++;
    if (rst_out_n !== !exp_asserted || rst_out !== exp_asserted) begin
      bad++;
      $display("FAIL %s: cycle %0d rst_out_n=%b rst_out=%b expected rst_out_n=%b rst_out=%b",
               tag, cyc, rst_out_n, rst_out, !exp_asserted, exp_asserted);
    end
    total++;
    if (rst_out !== !rst_out_n) begin
      bad++;
      $display("FAIL R2: cycle %0d rst_out=%b rst_out_n=%b expected inverse",
               cyc, rst_out, rst_out_n);
    end
  endtask

  // Monitor: pops expectations due at this cycle
  always @(negedge clk) begin
    while (expq.size() > 0 && expq[0].cyc <= cyc) begin
      exp_t it;
      it = expq.pop_front();
      if (it.cyc < cyc) begin
        total++;
        bad++;
        $display("FAIL %s: expectation for cycle %0d missed, now %0d expected on time",
                 it.tag, it.cyc, cyc);
      end else begin
        chk(it.asserted, it.tag);
      end
    end
  end

  // Driver helpers
  task automatic push_range(int from, int upto, bit a, string tag);
    for (int j = from; j <= upto; j++) expq.push_back('{cyc + j, a, tag});
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state while power-on reset is low
    step(3);
    chk(1'b1, "R1 reset state");
    por_n = 1'b1;
    push_range(1, LIM - 1, 1'b1, "R1 power-on stretch");
    push_range(LIM, LIM, 1'b0, "R1 power-on release");
    drain();

    // R3 / R4: supply-low hold and stretch
    supply_low = 1'b1;
    push_range(1, 6, 1'b1, "R3 supply low asserts");
    step(6);
    supply_low = 1'b0;
    push_range(1, LIM - 1, 1'b1, "R4 stretch after supply");
    push_range(LIM, LIM + 5, 1'b0, "R4 release and stay released");
    drain();

    // R5: retrigger during the stretch
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    push_range(1, 5, 1'b1, "R5 first stretch");
    step(5);
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    push_range(1, LIM - 1, 1'b1, "R5 restarted stretch");
    push_range(LIM, LIM, 1'b0, "R5 release after restart");
    drain();

    // R6 / R9: clean press, supply pulse inside it
    mr_n = 1'b0;
    push_range(1, FLT + 2, 1'b0, "R6 filter latency");
    push_range(FLT + 3, FLT + 3, 1'b1, "R6 press asserts");
    push_range(FLT + 4, 30, 1'b1, "R6 press held");
    step(10);
    supply_low = 1'b1;
    step(3);
    supply_low = 1'b0;
    step(17);
    mr_n = 1'b1;
    push_range(1, FLT + 1 + LIM, 1'b1, "R9 held until later source ends");
    push_range(FLT + 2 + LIM, FLT + 2 + LIM, 1'b0, "R8 release after press");
    drain();

    // R9: supply outlasts the press
    supply_low = 1'b1;
    mr_n = 1'b0;
    push_range(1, 2 * FLT + 12, 1'b1, "R9 both sources");
    step(FLT + 6);
    mr_n = 1'b1;
    step(FLT + 6);
    supply_low = 1'b0;
    push_range(1, LIM - 1, 1'b1, "R9 stretch from supply");
    push_range(LIM, LIM, 1'b0, "R9 release from supply");
    drain();

    // R7: glitch one cycle short of the filter
    mr_n = 1'b0;
    step(FLT - 1);
    mr_n = 1'b1;
    push_range(1, 30, 1'b0, "R7 short low ignored");
    drain();

    // R6: pulse exactly at the filter length
    mr_n = 1'b0;
    step(FLT);
    mr_n = 1'b1;
    push_range(1, 2, 1'b0, "R6 boundary before assert");
    push_range(3, FLT + 1 + LIM, 1'b1, "R6 boundary pulse accepted");
    push_range(FLT + 2 + LIM, FLT + 2 + LIM, 1'b0, "R8 boundary release");
    drain();

    // R8: bounce on release restarts the high run
    mr_n = 1'b0;
    step(FLT + 8);
    mr_n = 1'b1;
    push_range(1, FLT + 1, 1'b1, "R8 bounce high run");
    step(FLT - 1);
    mr_n = 1'b0;
    step(1);
    mr_n = 1'b1;
    push_range(1, FLT + 1 + LIM, 1'b1, "R8 bounce filtered");
    push_range(FLT + 2 + LIM, FLT + 2 + LIM, 1'b0, "R8 release after bounce");
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): ran 20000 cycles, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule